// File: doc/BRIEF.md
# Sequential Integer Multiply/Divide Unit

This unit computes unsigned 32-bit products and quotients one bit per clock. A single 64-bit working register holds either the accumulating product or the remainder and quotient pair. A 32-bit operand register holds the multiplicand or the divisor. A host pulses `start_i` with an opcode and two operands, then waits for `done_o`. `done_o` is a one-cycle strobe, and each result holds on its output until an operation of the same kind overwrites it.

Multiplication consumes the multiplier from its least significant bit upward. Before each step the unit tests the multiplier bits that remain. When they are all zero, the loop stops at once. One pass through a 64-bit right shifter then moves the partial product into its final position. Small multipliers therefore finish in far fewer than 32 steps. Division uses the restoring method and always takes 32 steps.

Top module: `muldiv_seq`

## Requirements
- R1: With `op_i`=0 (multiply), the unit produces `prod_o` equal to the exact 64-bit unsigned product `a_i*b_i`.
- R2: For a multiply accepted on edge T, `done_o` is high after edge T+h+2, where h is the index of the highest set bit of `b_i`. When `b_i`=0, `done_o` is high after edge T+1 and the product is 0.
- R3: With `op_i`=1 (divide) and `b_i`≠0, the unit produces `quot_o`=floor(`a_i`/`b_i`) and `rem_o`=`a_i` mod `b_i`, and `done_o` is high after edge T+32.
- R4: A divide with `b_i`=0 raises `done_o` and `div_err_o` after the accepting edge itself, and leaves `prod_o`, `quot_o` and `rem_o` unchanged. `div_err_o` holds until the next accepted start, which clears it.
- R5: `busy_o` is high from the accepting edge until the edge that raises `done_o`. It is low while `done_o` is high, and `done_o` lasts exactly one cycle. A divide by zero never raises `busy_o`.
- R6: While `busy_o` is high, `start_i` is ignored. The running operation keeps its operands, its result and its latency.
- R7: A multiply leaves `quot_o` and `rem_o` unchanged, and a divide leaves `prod_o` unchanged.
- R8: After reset, `busy_o`, `done_o` and `div_err_o` are low and `prod_o`, `quot_o` and `rem_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request an operation; sampled only while idle |
| op_i | input | 1 | 0 = multiply, 1 = divide |
| a_i | input | 32 | Multiplicand or dividend |
| b_i | input | 32 | Multiplier or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| div_err_o | output | 1 | Last accepted request was a divide by zero |
| prod_o | output | 64 | Product |
| quot_o | output | 32 | Quotient |
| rem_o | output | 32 | Remainder |

## Verification
A multiply's result is due h+2 edges after the accepting edge, where h is the index of the multiplier's top set bit, or one edge later when the multiplier is zero. A divide is due 32 edges after acceptance, and a divide by zero on the accepting edge itself. When the driver issues a request, it records the cycle number of the accepting edge and queues all three expected results, the error flag and the expected latency. The monitor samples on falling edges. When it sees `done_o`, it compares every output and checks that the elapsed cycle count equals the latency stored in the queued item.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MUL,
    ST_DIV
  } state_e;

  localparam logic OP_MUL = 1'b0;
  localparam logic OP_DIV = 1'b1;
endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned CW = $clog2(WIDTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          op_i,
  input  logic          div_zero_i,
  input  logic          mr_zero_i,
  output state_e        state_o,
  output logic [CW-1:0] cnt_o,
  output logic          load_o,
  output logic          fin_mul_o,
  output logic          fin_div_o,
  output logic          err_o
);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  state_e        state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          req;

  always_comb begin
    req       = (state_q == ST_IDLE) && start_i;
    err_o     = req && (op_i == OP_DIV) && div_zero_i;
    load_o    = req && !err_o;
    fin_mul_o = (state_q == ST_MUL) && mr_zero_i;
    fin_div_o = (state_q == ST_DIV) && (cnt_q == LAST);
    state_d   = state_q;
    cnt_d     = cnt_q;
    unique case (state_q)
      ST_IDLE: if (load_o) begin
        state_d = (op_i == OP_DIV) ? ST_DIV : ST_MUL;
        cnt_d   = '0;
      end
      ST_MUL: begin
        if (mr_zero_i) state_d = ST_IDLE;
        else           cnt_d   = cnt_q + CW'(1);
      end
      ST_DIV: begin
        if (fin_div_o) state_d = ST_IDLE;
        else           cnt_d   = cnt_q + CW'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;

  // R3: divide never leaves early
  a_r3_div_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DIV && cnt_q != LAST) |=> (state_q == ST_DIV));
  // R2: exhausted multiplier ends the loop next edge
  a_r2_mul_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MUL && mr_zero_i) |=> (state_q == ST_IDLE));
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MUL) |-> (cnt_q <= CW'(WIDTH)));
  // R6: a running operation is never restarted
  a_r6_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> (state_q == ST_IDLE || cnt_q != '0));
endmodule

// File: rtl/muldiv_dp.sv
module muldiv_dp
  import muldiv_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned CW = $clog2(WIDTH + 1),
  localparam int unsigned DW = 2 * WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  state_e           state_i,
  input  logic [CW-1:0]    cnt_i,
  input  logic             load_i,
  input  logic             fin_mul_i,
  input  logic             fin_div_i,
  input  logic             err_i,
  output logic             mr_zero_o,
  output logic             done_o,
  output logic             div_err_o,
  output logic [DW-1:0]    prod_o,
  output logic [WIDTH-1:0] quot_o,
  output logic [WIDTH-1:0] rem_o
);
  logic [DW-1:0]    acc_q;
  logic [WIDTH-1:0] mr_q, opnd_q;

  logic [WIDTH:0]   mul_add;
  logic [DW-1:0]    mul_next, mul_align, div_next;
  logic [CW-1:0]    shamt;
  logic [WIDTH:0]   rem_sh;
  logic [WIDTH+1:0] div_diff;
  logic             div_ok;

  always_comb begin
    mul_add   = {1'b0, acc_q[DW-1:WIDTH]} + (mr_q[0] ? {1'b0, opnd_q} : '0);
    mul_next  = {mul_add, acc_q[WIDTH-1:1]};
    // skipped positions = WIDTH - steps taken
    shamt     = CW'(WIDTH) - cnt_i;
    mul_align = acc_q >> shamt;
    rem_sh    = acc_q[DW-1:WIDTH-1];
    div_diff  = {1'b0, rem_sh} - {2'b0, opnd_q};
    div_ok    = !div_diff[WIDTH+1];
    div_next  = {(div_ok ? div_diff[WIDTH-1:0] : rem_sh[WIDTH-1:0]),
                 acc_q[WIDTH-2:0], div_ok};
  end

  assign mr_zero_o = (mr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      mr_q      <= '0;
      opnd_q    <= '0;
      done_o    <= 1'b0;
      div_err_o <= 1'b0;
      prod_o    <= '0;
      quot_o    <= '0;
      rem_o     <= '0;
    end else begin
      done_o <= fin_mul_i | fin_div_i | err_i;
      if (err_i)       div_err_o <= 1'b1;
      else if (load_i) div_err_o <= 1'b0;
      if (load_i) begin
        if (op_i == OP_MUL) begin
          acc_q  <= '0;
          mr_q   <= b_i;
          opnd_q <= a_i;
        end else begin
          acc_q  <= {{WIDTH{1'b0}}, a_i};
          mr_q   <= '0;
          opnd_q <= b_i;
        end
      end else if (state_i == ST_MUL && !mr_zero_o) begin
        acc_q <= mul_next;
        mr_q  <= mr_q >> 1;
      end else if (state_i == ST_DIV) begin
        acc_q <= div_next;
      end
      if (fin_mul_i) prod_o <= mul_align;
      if (fin_div_i) begin
        quot_o <= div_next[WIDTH-1:0];
        rem_o  <= div_next[DW-1:WIDTH];
      end
    end
  end

  // R3: remainder is below divisor
  a_r3_rem_below: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_div_i |=> (rem_o < opnd_q));
  // R4: error flag appears only together with completion
  a_r4_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_err_o) |-> done_o);
  // R7: divide does not disturb product
  a_r7_prod_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_div_i |=> $stable(prod_o));
  // R7: multiply does not disturb quotient/remainder
  a_r7_qr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_mul_i |=> ($stable(quot_o) && $stable(rem_o)));
endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
  import muldiv_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned CW = $clog2(WIDTH + 1),
  localparam int unsigned DW = 2 * WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             div_err_o,
  output logic [DW-1:0]    prod_o,
  output logic [WIDTH-1:0] quot_o,
  output logic [WIDTH-1:0] rem_o
);
  state_e        state;
  logic [CW-1:0] cnt;
  logic          load, fin_mul, fin_div, err, mr_zero;

  muldiv_ctrl #(.WIDTH(WIDTH)) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .op_i      (op_i),
    .div_zero_i(b_i == '0),
    .mr_zero_i (mr_zero),
    .state_o   (state),
    .cnt_o     (cnt),
    .load_o    (load),
    .fin_mul_o (fin_mul),
    .fin_div_o (fin_div),
    .err_o     (err)
  );

  muldiv_dp #(.WIDTH(WIDTH)) i_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .state_i   (state),
    .cnt_i     (cnt),
    .load_i    (load),
    .fin_mul_i (fin_mul),
    .fin_div_i (fin_div),
    .err_i     (err),
    .mr_zero_o (mr_zero),
    .done_o    (done_o),
    .div_err_o (div_err_o),
    .prod_o    (prod_o),
    .quot_o    (quot_o),
    .rem_o     (rem_o)
  );

  assign busy_o = (state != ST_IDLE);

  // R5: completion strobe only while idle
  a_r5_idle_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R4: divide by zero never enters the busy phase
  a_r4_no_busy_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err |=> !busy_o);
endmodule

// File: tb/test_muldiv_seq.sv
`timescale 1ns/1ps
module test_muldiv_seq;
  typedef struct {
    logic [63:0] prod;
    logic [31:0] quot;
    logic [31:0] rem;
    logic        err;
    int          t_acc;
    int          lat;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        busy, done, div_err;
  logic [63:0] prod;
  logic [31:0] quot, rem;

  int n_chk = 0, n_err = 0, cyc = 0;
  item_t sb[$];
  logic [63:0] m_prod = '0;
  logic [31:0] m_quot = '0, m_rem = '0;
  bit mon_on = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  muldiv_seq i_muldiv_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .a_i(a), .b_i(b),
    .busy_o(busy), .done_o(done), .div_err_o(div_err),
    .prod_o(prod), .quot_o(quot), .rem_o(rem)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int top_bit(logic [31:0] v);
    for (int i = 31; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  task automatic run_op(logic o, logic [31:0] x, logic [31:0] y, bit junk);
    item_t it;
    if (o == 1'b0) begin
      m_prod = {32'b0, x} * {32'b0, y};
      it.err = 1'b0;
      it.lat = (y == 0) ? 1 : top_bit(y) + 2;
      it.req = "R1/R2";
    end else if (y == 0) begin
      it.err = 1'b1;
      it.lat = 0;
      it.req = "R4";
    end else begin
      m_quot = x / y;
      m_rem  = x % y;
      it.err = 1'b0;
      it.lat = 32;
      it.req = "R3";
    end
    it.prod = m_prod;
    it.quot = m_quot;
    it.rem  = m_rem;
    @(negedge clk);
    start = 1'b1; op = o; a = x; b = y;
    it.t_acc = cyc + 1;
    sb.push_back(it);
    @(negedge clk);
    if (junk) begin
      op = ~o; a = ~x; b = y ^ 32'h5a5a_0001;
    end else begin
      start = 1'b0;
    end
    if (!(o == 1'b1 && y == 0)) chk("R5", "busy after accept", 64'(busy), 64'd1);
    else                        chk("R5", "no busy on div0", 64'(busy), 64'd0);
    if (junk) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        op = $urandom; a = $urandom; b = $urandom | 32'h1;
      end
      start = 1'b0;
    end
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    bit prev_done = 1'b0;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (prev_done) chk("R5", "done one cycle", 64'(done), 64'd0);
        if (done) begin
          if (sb.size() == 0) begin
            n_chk++; n_err++;
            $display("FAIL R5 unexpected done: actual=1 expected=0");
          end else begin
            item_t e;
            e = sb.pop_front();
            chk(e.req, "prod (R7 hold)", prod, e.prod);
            chk(e.req, "quot (R7 hold)", 64'(quot), 64'(e.quot));
            chk(e.req, "rem (R7 hold)", 64'(rem), 64'(e.rem));
            chk(e.req, "div_err (R4)", 64'(div_err), 64'(e.err));
            chk(e.req, "latency (R2/R3/R6)", 64'(cyc - e.t_acc), 64'(e.lat));
            chk("R5", "busy low at done", 64'(busy), 64'd0);
          end
        end
        prev_done = done;
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk("R8", "busy", 64'(busy), 64'd0);
        chk("R8", "done", 64'(done), 64'd0);
        chk("R8", "div_err", 64'(div_err), 64'd0);
        chk("R8", "prod", prod, 64'd0);
        chk("R8", "quot", 64'(quot), 64'd0);
        chk("R8", "rem", 64'(rem), 64'd0);
        mon_on = 1'b1;
        run_op(1'b0, 32'd12345, 32'd0, 1'b0);          // R2 zero multiplier
        run_op(1'b0, 32'hdead_beef, 32'd1, 1'b0);      // R2 shortest loop
        run_op(1'b0, 32'd1000, 32'd13, 1'b0);          // R1 early exit
        run_op(1'b0, 32'hffff_ffff, 32'hffff_ffff, 1'b1); // R1 full, R6 junk
        run_op(1'b0, 32'h8000_0001, 32'h8000_0000, 1'b0); // R2 top bit
        run_op(1'b1, 32'd100, 32'd7, 1'b0);            // R3
        run_op(1'b1, 32'd5, 32'd9, 1'b0);              // R3 quotient 0
        run_op(1'b1, 32'hffff_ffff, 32'd1, 1'b0);      // R3 divide by 1
        run_op(1'b1, 32'hffff_ffff, 32'hffff_ffff, 1'b0);
        run_op(1'b1, 32'd77, 32'd0, 1'b0);             // R4 divide by zero
        run_op(1'b0, 32'd3, 32'd5, 1'b0);              // R4 flag clears
        run_op(1'b1, 32'h1234_5678, 32'd0, 1'b0);      // R4 again
        run_op(1'b1, 32'hcafe_f00d, 32'h0000_0123, 1'b1); // R6 junk during divide
        for (int i = 0; i < 40; i++) begin
          logic [31:0] x, y;
          x = $urandom;
          y = $urandom >> ($urandom % 32);
          run_op(1'(i % 2), x, y, 1'b0);
        end
      end
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule